// File: doc/BRIEF.md
# Wide Right Shifter with Sticky Fold

This block shifts a 128-bit quantity to the right by an unsigned count. The quantity arrives as two 64-bit halves, a high half and a low half. Bits that fall off the bottom are not simply lost. Any set bit among them forces the least significant bit of the result to 1. A later rounding stage can then still tell that the shifted value is inexact.

The block sits in the datapath of a fused multiply-add unit. It is used there for two jobs: lining up the product and the addend before they are summed, and narrowing the wide sum down to a mantissa plus guard bits. The block is purely combinational and holds no state.

The count spans 0 to 255. Counts of 128 or more remove every bit of the value, so the result collapses to a single sticky bit.

The count is classified into one of five regions:
- pass: count 0
- near: 1 to 63
- exact-half: 64
- far: 65 to 127
- flush: 128 and up

These regions are combinational; there is no state register and no transition.

Top module: `wide_sticky_shr`

## Requirements
- R1: When the count is 128 or more, the high output is 0. The low output is 1 if any of the 128 input bits is set, and 0 otherwise.
- R2: When the count is exactly 64, the high output is 0. The low output equals the high input, with bit 0 ORed with the OR of all low input bits.
- R3: When the count is from 65 to 127, the high output is 0. The low output is the high input shifted right by (count − 64). Its bit 0 is ORed with every high input bit shifted out and with every low input bit.
- R4: When the count is from 1 to 63, the high output is the high input shifted right by the count. The low output takes the bottom count bits of the high input in its top positions and the low input shifted right by the count below them. Its bit 0 is ORed with the count bits dropped from the low input.
- R5: A count of 0 returns both halves unchanged.
- R6: A nonzero input always gives a nonzero output, whatever the count.
- R7: When every discarded bit is 0, the output is the exact logical right shift of the 128-bit value, with no extra bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hi_i | input | 64 | Upper half of the value (bit 63 is the value's MSB) |
| lo_i | input | 64 | Lower half of the value |
| cnt_i | input | 8 | Unsigned shift distance |
| hi_o | output | 64 | Upper half of the shifted value |
| lo_o | output | 64 | Lower half of the shifted value, with sticky bit 0 |

## Verification
The bench goes after these corner cases:

| Corner case | How a faulty design fails |
|---|---|
| Count 64, and counts 63, 65, 127 and 128 around it | A design that ignores the low half at 64 or past it drops the sticky bit. |
| A single set bit in the low half, pushed out by a far shift | Shows whether sticky is missed. |
| A value with exactly one set bit at bit 0 under the largest counts | A flush path that tests only the high half returns zero here instead of 1. |
| Count 0 | Catches a stage that ORs sticky in unconditionally; bit 0 of an even value then turns to 1. |
| Shifts whose discarded bits are all clear | Catches the same fault. |

A sweep of every count against several patterns compares each result with a wide shift followed by an OR-reduction of the discarded bits.

// File: rtl/wsh_pkg.sv
package wsh_pkg;

    // Which span of shift distances the count falls into.
    typedef enum logic [2:0] {
        RG_PASS       = 3'd0,  // no shift at all
        RG_NEAR       = 3'd1,  // bits cross from the upper half into the lower
        RG_EXACT_HALF = 3'd2,  // upper half lands exactly on the lower half
        RG_FAR        = 3'd3,  // only part of the upper half survives
        RG_FLUSH      = 3'd4   // nothing survives but the sticky bit
    } wsh_region_e;

endpackage

// File: rtl/wsh_region.sv
module wsh_region
    import wsh_pkg::*;
#(
    parameter int unsigned HALF_W = 64,
    parameter int unsigned CNT_W  = 8
) (
    input  logic [CNT_W-1:0] cnt_i,
    output wsh_region_e      region_o
);
    localparam int unsigned VAL_W = 2 * HALF_W;
    localparam logic [CNT_W:0] LIM_HALF = (CNT_W + 1)'(HALF_W);
    localparam logic [CNT_W:0] LIM_FULL = (CNT_W + 1)'(VAL_W);

    logic [CNT_W:0] cnt_ext;

    always_comb begin
        cnt_ext = {1'b0, cnt_i};
        if (cnt_ext == '0) begin
            region_o = RG_PASS;
        end else if (cnt_ext < LIM_HALF) begin
            region_o = RG_NEAR;
        end else if (cnt_ext == LIM_HALF) begin
            region_o = RG_EXACT_HALF;
        end else if (cnt_ext < LIM_FULL) begin
            region_o = RG_FAR;
        end else begin
            region_o = RG_FLUSH;
        end
    end

endmodule

// File: rtl/wsh_stage.sv
module wsh_stage #(
    parameter int unsigned VAL_W = 128,
    parameter int unsigned SHIFT = 1
) (
    input  logic [VAL_W-1:0] val_i,
    input  logic             en_i,
    output logic [VAL_W-1:0] val_o
);
    logic [VAL_W-1:0] moved;
    logic             lost;

    generate
        if (SHIFT >= VAL_W) begin : g_drop_all
            always_comb begin
                moved = '0;
                lost  = |val_i;
            end
        end else begin : g_partial
            always_comb begin
                moved = val_i >> SHIFT;
                lost  = |val_i[SHIFT-1:0];
            end
        end
    endgenerate

    always_comb begin
        if (en_i) begin
            val_o = moved | {{(VAL_W-1){1'b0}}, lost};
        end else begin
            val_o = val_i;
        end
    end

    // R6: a stage never turns a nonzero value into zero
    always_comb begin
        if (|val_i) begin
            p_nonzero_kept_r6: assert (|val_o)
                else $error("stage SHIFT=%0d lost every set bit", SHIFT);
        end
    end

endmodule

// File: rtl/wide_sticky_shr.sv
module wide_sticky_shr
    import wsh_pkg::*;
#(
    parameter int unsigned HALF_W = 64,
    parameter int unsigned CNT_W  = 8
) (
    input  logic [HALF_W-1:0] hi_i,
    input  logic [HALF_W-1:0] lo_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [HALF_W-1:0] hi_o,
    output logic [HALF_W-1:0] lo_o
);
    localparam int unsigned VAL_W = 2 * HALF_W;

    wsh_region_e      region;
    logic [VAL_W-1:0] val_in;
    logic [VAL_W-1:0] chain [CNT_W+1];
    logic [VAL_W-1:0] flush_val;
    logic [VAL_W-1:0] result;

    assign val_in   = {hi_i, lo_i};
    assign chain[0] = val_in;

    wsh_region #(
        .HALF_W (HALF_W),
        .CNT_W  (CNT_W)
    ) u_region (
        .cnt_i    (cnt_i),
        .region_o (region)
    );

    // One stage per count bit, each shifting by a power of two.
    generate
        for (genvar k = 0; k < CNT_W; k++) begin : g_stage
            wsh_stage #(
                .VAL_W (VAL_W),
                .SHIFT (1 << k)
            ) u_stage (
                .val_i (chain[k]),
                .en_i  (cnt_i[k]),
                .val_o (chain[k+1])
            );
        end
    endgenerate

    // A shift past the whole width takes the short path: one OR tree.
    assign flush_val = {{(VAL_W-1){1'b0}}, |val_in};

    always_comb begin
        unique case (region)
            RG_PASS:  result = val_in;
            RG_FLUSH: result = flush_val;
            default:  result = chain[CNT_W];
        endcase
    end

    assign hi_o = result[VAL_W-1:HALF_W];
    assign lo_o = result[HALF_W-1:0];

    always_comb begin
        // R1: the stage chain and the flush path agree
        if (region == RG_FLUSH) begin
            p_flush_agree_r1: assert (chain[CNT_W] == flush_val)
                else $error("flush path and stage chain disagree");
        end
        // R5: zero count is a pure pass-through
        if (cnt_i == '0) begin
            p_pass_through_r5: assert ({hi_o, lo_o} == val_in)
                else $error("zero count altered the value");
        end
        // R2 and R3: from one half-width onward the upper half is empty
        if (region == RG_EXACT_HALF || region == RG_FAR || region == RG_FLUSH) begin
            p_high_cleared_r3: assert (hi_o == '0)
                else $error("upper half not cleared");
        end
        // R4: the upper half is a plain shift for short distances
        if (region == RG_NEAR) begin
            p_hi_shift_r4: assert (hi_o == (hi_i >> cnt_i))
                else $error("upper half wrong for short shift");
        end
    end

endmodule

// File: tb/wide_sticky_shr_tb.sv
module wide_sticky_shr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic [63:0] hi_i, lo_i, hi_o, lo_o;
    logic [7:0]  cnt_i;
    int          n_vec  = 0;
    int          n_fail = 0;
    int          cycles = 0;
    bit          done   = 0;
    logic [63:0] seed   = 64'h9E37_79B9_7F4A_7C15;

    always #(CLK_PERIOD/2) clk = ~clk;

    wide_sticky_shr u_dut (
        .hi_i  (hi_i),
        .lo_i  (lo_i),
        .cnt_i (cnt_i),
        .hi_o  (hi_o),
        .lo_o  (lo_o)
    );

    // Model: wide logical shift, then OR every discarded bit into bit 0.
    function automatic logic [127:0] model(input logic [63:0] h, input logic [63:0] l,
                                           input logic [7:0] c);
        logic [127:0] v, kept, mask;
        v    = {h, l};
        kept = v >> c;
        mask = ~({128{1'b1}} << c);
        kept[0] = kept[0] | (|(v & mask));
        return kept;
    endfunction

    function automatic logic [63:0] next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    task automatic apply(input logic [63:0] h, input logic [63:0] l,
                         input logic [7:0] c, input string req);
        logic [127:0] exp_v;
        @(negedge clk);
        hi_i = h; lo_i = l; cnt_i = c;
        #1;
        exp_v = model(h, l, c);
        n_vec++;
        if ({hi_o, lo_o} !== exp_v) begin
            n_fail++;
            $display("FAIL %s cnt=%0d in=%h_%h actual=%h_%h expected=%h",
                     req, c, h, l, hi_o, lo_o, exp_v);
        end
    endtask

    task automatic t_idle_zero();
        apply(64'h0, 64'h0, 8'd0, "R5");
        apply(64'h0, 64'h0, 8'd255, "R1");
    endtask

    task automatic t_pass_r5();
        apply(64'hDEAD_BEEF_0123_4567, 64'h89AB_CDEF_FEDC_BA98, 8'd0, "R5");
        apply(64'h0, 64'h2, 8'd0, "R5");
    endtask

    task automatic t_near_r4();
        apply(64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001, 8'd1, "R4");
        apply(64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_0000_1000, 8'd13, "R4");
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h4000_0000_0000_0000, 8'd63, "R4");
    endtask

    task automatic t_exact_r2();
        apply(64'h1234_5678_9ABC_DEF0, 64'h0, 8'd64, "R2");
        apply(64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0001, 8'd64, "R2");
    endtask

    task automatic t_far_r3();
        apply(64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 8'd65, "R3");
        apply(64'hF000_0000_0000_0001, 64'h0, 8'd100, "R3");
        apply(64'h8000_0000_0000_0000, 64'h0, 8'd127, "R3");
        apply(64'h4000_0000_0000_0000, 64'h0, 8'd127, "R3");
    endtask

    task automatic t_flush_r1();
        apply(64'h0, 64'h0000_0000_0000_0001, 8'd128, "R1");
        apply(64'h8000_0000_0000_0000, 64'h0, 8'd200, "R1");
        apply(64'h0, 64'h0, 8'd128, "R1");
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'd255, "R1");
    endtask

    task automatic t_clean_r7();
        apply(64'h0000_0000_0000_0100, 64'h0, 8'd8, "R7");
        apply(64'h0000_0000_0000_0000, 64'hFF00, 8'd8, "R7");
        apply(64'hABCD_0000_0000_0000, 64'h0, 8'd64, "R7");
        apply(64'hABCD_0000_0000_0000, 64'h0, 8'd112, "R7");
    endtask

    task automatic t_single_bit_r6();
        for (int b = 0; b < 128; b += 9) begin
            logic [127:0] v;
            v = 128'd1 << b;
            for (int c = 0; c < 256; c += 17) begin
                apply(v[127:64], v[63:0], 8'(c), "R6");
                if ({hi_o, lo_o} == '0) begin
                    n_fail++;
                    $display("FAIL R6 bit=%0d cnt=%0d actual=0 expected=nonzero", b, c);
                end
            end
        end
    endtask

    task automatic t_sweep_all();
        for (int c = 0; c < 256; c++) begin
            for (int p = 0; p < 4; p++) begin
                apply(next_rand(), next_rand(), 8'(c),
                      c == 0 ? "R5" : c < 64 ? "R4" : c == 64 ? "R2" : c < 128 ? "R3" : "R1");
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            n_fail++;
            $display("FAIL watchdog expired after %0d cycles (expected completion)", cycles);
            finish_run();
        end
    end

    initial begin
        hi_i = '0; lo_i = '0; cnt_i = '0;
        t_idle_zero();
        t_pass_r5();
        t_near_r4();
        t_exact_r2();
        t_far_r3();
        t_flush_r1();
        t_clean_r7();
        t_single_bit_r6();
        t_sweep_all();
        finish_run();
    end

endmodule